// File: doc/BRIEF.md
# Self-starting ring counter

This block circulates a single HIGH bit through a chain of flip-flops, advancing one stage per enabled clock edge. The output vector is already a decoded one-of-N count, so it serves directly as a sequencer or phase selector with no decoder behind it. All stages load on the same edge.

The stage that feeds the first flip-flop is not wired straight to the last stage. A HIGH enters only when every stage except the last is clear. Otherwise a LOW enters. Any illegal pattern, such as a power-up pattern with several ones or with none, therefore drains out of the chain. The ring then starts itself without an explicit preset.

A synchronous reset is optional and is chosen by a parameter. Without it, the power-up value of the chain is a parameter. A flag reports whenever the vector holds exactly one set bit. A second parameter selects the circuit style used to build that flag.

Top module: `ring_selfstart`

## Requirements
- R1: The modulus equals STAGES. Starting from the start state with enable held high, the vector first equals the start state again after exactly STAGES clocks, and every state it passes through has one set bit.
- R2: Bit STAGES-1 is the first stage and bit 0 is the last. The start state has only bit STAGES-1 set. On each enabled edge, every bit k below STAGES-1 takes the old value of bit k+1. For 4 stages the legal sequence is 1000, 0100, 0010, 0001, 1000.
- R3: On each enabled edge, bit STAGES-1 becomes 1 if and only if bits STAGES-1 down to 1 were all 0 before the edge; otherwise it becomes 0.
- R4: The all-zero vector becomes the start state after one enabled edge.
- R5: From any of the 2^STAGES possible initial vectors, the counter holds exactly one set bit after at most STAGES+1 enabled edges. Once it holds one set bit, it keeps exactly one set bit.
- R6: With RST_MODE = sync, a high reset loads the start state on the next edge. Reset wins over enable.
- R7: While enable is low, the vector keeps its value across edges.
- R8: valid_o is 1 exactly when the vector has one bit set. It follows the vector in the same cycle.
- R9: With RST_MODE = none, the vector holds PWRUP_STATE before the first edge, and the reset input has no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all stages load on its rising edge |
| rst_i | input | 1 | Synchronous reset to the start state (sync mode only) |
| en_i | input | 1 | Advance enable; low holds the vector |
| state_o | output | STAGES | Stage vector, bit STAGES-1 is the first stage |
| valid_o | output | 1 | High when state_o has exactly one bit set |

## Verification
The main instance has 4 stages, the synchronous reset and the scanning detector. This instance covers the legal rotation, hold, reset priority and the modulus count. Two banks of no-reset instances, one with 4 stages and one with 5, use the masking detector. Each instance powers up in a different pattern, so all 16 and all 32 initial vectors are covered without any load port. These banks allow every recovery path to be compared edge by edge with the injection rule, while their reset input is held high to show that it is ignored.

// File: rtl/ring_pkg.sv
package ring_pkg;

   // how the stage register can be returned to the start state
   typedef enum logic [0:0] {
      RING_RST_NONE = 1'b0,
      RING_RST_SYNC = 1'b1
   } ring_rst_e;

   // circuit style of the one-hot flag
   typedef enum logic [0:0] {
      ONEHOT_SCAN = 1'b0,
      ONEHOT_MASK = 1'b1
   } onehot_style_e;

endpackage

// File: rtl/ring_feedback.sv
module ring_feedback #(
   parameter int STAGES = 4
) (
   input  logic [STAGES-1:0] cur_i,
   output logic [STAGES-1:0] nxt_o
);
   localparam int UPPER = STAGES - 1;

   logic upper_busy;
   logic inject;

   // any set bit among the stages that are not the last one
   assign upper_busy = |cur_i[STAGES-1:1];
   assign inject     = ~upper_busy;

   // first stage gets the injected bit, the rest move one place down
   assign nxt_o[STAGES-1] = inject;

   for (genvar k = 0; k < UPPER; k++) begin : g_shift
      assign nxt_o[k] = cur_i[k+1];
   end

endmodule

// File: rtl/ring_stage_reg.sv
module ring_stage_reg #(
   parameter int                  STAGES      = 4,
   parameter ring_pkg::ring_rst_e RST_MODE    = ring_pkg::RING_RST_SYNC,
   parameter logic [STAGES-1:0]   PWRUP_STATE = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [STAGES-1:0] d_i,
   output logic [STAGES-1:0] q_o
);
   localparam logic [STAGES-1:0] START = STAGES'(1) << (STAGES - 1);

   logic [STAGES-1:0] q_r = PWRUP_STATE;

   if (RST_MODE == ring_pkg::RING_RST_SYNC) begin : g_sync
      always_ff @(posedge clk_i) begin
         if (rst_i)     q_r <= START;
         else if (en_i) q_r <= d_i;
      end
   end else begin : g_free
      logic unused_rst;
      assign unused_rst = rst_i;
      always_ff @(posedge clk_i) begin
         if (en_i) q_r <= d_i;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/ring_onehot_detect.sv
module ring_onehot_detect #(
   parameter int                      STAGES = 4,
   parameter ring_pkg::onehot_style_e STYLE  = ring_pkg::ONEHOT_SCAN
) (
   input  logic [STAGES-1:0] vec_i,
   output logic              hit_o
);
   if (STYLE == ring_pkg::ONEHOT_SCAN) begin : g_scan
      // seen: some bit set so far; twice: a second set bit was found
      logic [STAGES:0] seen;
      logic [STAGES:0] twice;
      assign seen[0]  = 1'b0;
      assign twice[0] = 1'b0;
      for (genvar k = 0; k < STAGES; k++) begin : g_bit
         assign seen[k+1]  = seen[k] | vec_i[k];
         assign twice[k+1] = twice[k] | (seen[k] & vec_i[k]);
      end
      assign hit_o = seen[STAGES] & ~twice[STAGES];
   end else begin : g_mask
      // clearing the lowest set bit leaves zero only for a power of two
      logic [STAGES-1:0] low_cleared;
      assign low_cleared = vec_i & (vec_i - STAGES'(1));
      assign hit_o = (|vec_i) & ~(|low_cleared);
   end

endmodule

// File: rtl/ring_selfstart.sv
module ring_selfstart #(
   parameter int                      STAGES      = 4,
   parameter ring_pkg::ring_rst_e     RST_MODE    = ring_pkg::RING_RST_SYNC,
   parameter logic [STAGES-1:0]       PWRUP_STATE = '0,
   parameter ring_pkg::onehot_style_e CHECK_STYLE = ring_pkg::ONEHOT_SCAN
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   output logic [STAGES-1:0] state_o,
   output logic              valid_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ring_selfstart: STAGES must be at least 2");
   end

   logic [STAGES-1:0] cur;
   logic [STAGES-1:0] nxt;

   ring_feedback #(
      .STAGES (STAGES)
   ) u_fb (
      .cur_i (cur),
      .nxt_o (nxt)
   );

   ring_stage_reg #(
      .STAGES      (STAGES),
      .RST_MODE    (RST_MODE),
      .PWRUP_STATE (PWRUP_STATE)
   ) u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .d_i   (nxt),
      .q_o   (cur)
   );

   ring_onehot_detect #(
      .STAGES (STAGES),
      .STYLE  (CHECK_STYLE)
   ) u_det (
      .vec_i (cur),
      .hit_o (valid_o)
   );

   assign state_o = cur;

endmodule

// File: rtl/ring_selfstart_chk.sv
module ring_selfstart_chk #(
   parameter int                  STAGES   = 4,
   parameter ring_pkg::ring_rst_e RST_MODE = ring_pkg::RING_RST_SYNC
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic [STAGES-1:0] state_i,
   input logic              valid_i
);
   localparam logic [STAGES-1:0] START = STAGES'(1) << (STAGES - 1);

   logic rst_eff;
   assign rst_eff = (RST_MODE == ring_pkg::RING_RST_SYNC) & rst_i;

   // legal states rotate one place per enabled edge
   p_rotate_r2: assert property (@(posedge clk_i) disable iff (rst_eff)
      (en_i && valid_i) |=> state_i == {$past(state_i[0]), $past(state_i[STAGES-1:1])});

   // first stage is set only after the upper stages were all clear
   p_inject_hi_r3: assert property (@(posedge clk_i) disable iff (rst_eff)
      (en_i && state_i[STAGES-1:1] == '0) |=> state_i[STAGES-1]);

   p_inject_lo_r3: assert property (@(posedge clk_i) disable iff (rst_eff)
      (en_i && state_i[STAGES-1:1] != '0) |=> !state_i[STAGES-1]);

   p_zero_start_r4: assert property (@(posedge clk_i) disable iff (rst_eff)
      (en_i && state_i == '0) |=> state_i == START);

   p_stay_legal_r5: assert property (@(posedge clk_i) disable iff (rst_eff)
      valid_i |=> valid_i);

   p_hold_r7: assert property (@(posedge clk_i) disable iff (rst_eff)
      !en_i |=> $stable(state_i));

   p_flag_r8: assert property (@(posedge clk_i)
      valid_i == ($countones(state_i) == 1));

   if (RST_MODE == ring_pkg::RING_RST_SYNC) begin : g_rst_chk
      p_reset_r6: assert property (@(posedge clk_i)
         rst_i |=> state_i == START);
   end

endmodule

bind ring_selfstart ring_selfstart_chk #(
   .STAGES   (STAGES),
   .RST_MODE (RST_MODE)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .en_i    (en_i),
   .state_i (state_o),
   .valid_i (valid_o)
);

// File: tb/sim_ring_selfstart.sv
module sim_ring_selfstart;
   import ring_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // next vector per R2/R3, for width w up to 8
   function automatic logic [7:0] rule_next(input logic [7:0] s, input int w);
      logic [7:0] upper;
      upper = (s >> 1) & ((8'd1 << (w - 1)) - 8'd1);
      return upper | ((upper == 8'd0) ? (8'd1 << (w - 1)) : 8'd0);
   endfunction

   // main instance
   logic       rst0 = 1'b1;
   logic       en0  = 1'b0;
   logic [3:0] q0;
   logic       v0;

   ring_selfstart #(
      .STAGES      (4),
      .RST_MODE    (RING_RST_SYNC),
      .PWRUP_STATE (4'b0110),
      .CHECK_STYLE (ONEHOT_SCAN)
   ) u0 (
      .clk_i   (clk),
      .rst_i   (rst0),
      .en_i    (en0),
      .state_o (q0),
      .valid_o (v0)
   );

   // banks of no-reset instances, one per power-up vector
   logic              sw_en  = 1'b0;
   logic              sw_rst = 1'b0;
   logic [15:0][3:0]  s4_q;
   logic [15:0]       s4_v;
   logic [31:0][4:0]  s5_q;
   logic [31:0]       s5_v;

   for (genvar g = 0; g < 16; g++) begin : g_s4
      ring_selfstart #(
         .STAGES      (4),
         .RST_MODE    (RING_RST_NONE),
         .PWRUP_STATE (4'(g)),
         .CHECK_STYLE (ONEHOT_MASK)
      ) u_s4 (
         .clk_i   (clk),
         .rst_i   (sw_rst),
         .en_i    (sw_en),
         .state_o (s4_q[g]),
         .valid_o (s4_v[g])
      );
   end

   for (genvar g = 0; g < 32; g++) begin : g_s5
      ring_selfstart #(
         .STAGES      (5),
         .RST_MODE    (RING_RST_NONE),
         .PWRUP_STATE (5'(g)),
         .CHECK_STYLE (ONEHOT_MASK)
      ) u_s5 (
         .clk_i   (clk),
         .rst_i   (sw_rst),
         .en_i    (sw_en),
         .state_o (s5_q[g]),
         .valid_o (s5_v[g])
      );
   end

   typedef struct packed {
      logic       rst;
      logic       en;
      logic [3:0] exp;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t TBL [NVEC] = '{
      '{1'b1, 1'b0, 4'b1000},   // R6 reset wins with enable low
      '{1'b0, 1'b1, 4'b0100},   // R2
      '{1'b0, 1'b1, 4'b0010},   // R2
      '{1'b0, 1'b0, 4'b0010},   // R7 hold
      '{1'b0, 1'b1, 4'b0001},   // R2
      '{1'b0, 1'b1, 4'b1000},   // R2 wrap from last stage
      '{1'b0, 1'b1, 4'b0100},   // R2
      '{1'b1, 1'b1, 4'b1000},   // R6 reset wins over enable
      '{1'b0, 1'b0, 4'b1000},   // R7 hold
      '{1'b0, 1'b1, 4'b0100},
      '{1'b0, 1'b1, 4'b0010},
      '{1'b0, 1'b1, 4'b0001},
      '{1'b1, 1'b0, 4'b1000},   // R6
      '{1'b0, 1'b1, 4'b0100}
   };

   initial begin : main
      logic [7:0] m4 [16];
      logic [7:0] m5 [32];
      int         laps;

      // R9 power-up vector and R8 flag before any edge
      #2;
      for (int k = 0; k < 16; k++) begin
         m4[k] = 8'(k);
         check("R9", "power-up 4-stage", 32'(s4_q[k]), 32'(k));
         check("R8", "flag 4-stage", 32'(s4_v[k]), 32'($countones(4'(k)) == 1));
      end
      for (int k = 0; k < 32; k++) begin
         m5[k] = 8'(k);
         check("R9", "power-up 5-stage", 32'(s5_q[k]), 32'(k));
         check("R8", "flag 5-stage", 32'(s5_v[k]), 32'($countones(5'(k)) == 1));
      end

      // R7 one edge with enable low leaves every bank vector alone
      @(posedge clk); #5;
      for (int k = 0; k < 16; k++)
         check("R7", "bank hold", 32'(s4_q[k]), 32'(k));

      // recovery with reset held high, which these instances ignore (R9)
      @(negedge clk);
      sw_en  = 1'b1;
      sw_rst = 1'b1;
      for (int step = 1; step <= 6; step++) begin
         @(posedge clk); #5;
         for (int k = 0; k < 16; k++) begin
            m4[k] = rule_next(m4[k], 4);
            check("R3", "4-stage step", 32'(s4_q[k]), 32'(m4[k][3:0]));
            check("R8", "4-stage flag", 32'(s4_v[k]), 32'($countones(m4[k]) == 1));
            if (step == 5)
               check("R5", "4-stage one-hot by N+1", 32'(s4_v[k]), 32'd1);
         end
         for (int k = 0; k < 32; k++) begin
            m5[k] = rule_next(m5[k], 5);
            check("R3", "5-stage step", 32'(s5_q[k]), 32'(m5[k][4:0]));
            if (step == 6)
               check("R5", "5-stage one-hot by N+1", 32'(s5_v[k]), 32'd1);
         end
         if (step == 1) begin
            check("R4", "4-stage zero restarts", 32'(s4_q[0]), 32'h8);
            check("R4", "5-stage zero restarts", 32'(s5_q[0]), 32'h10);
            check("R9", "reset ignored", 32'(s4_q[3]), 32'h1);
         end
      end
      @(negedge clk);
      sw_en  = 1'b0;
      sw_rst = 1'b0;

      // vector table on the main instance
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         rst0 = TBL[i].rst;
         en0  = TBL[i].en;
         @(posedge clk); #5;
         check("R2", $sformatf("table step %0d", i), 32'(q0), 32'(TBL[i].exp));
         check("R8", $sformatf("table flag %0d", i), 32'(v0), 32'd1);
      end

      // R1 modulus: count edges until the start state comes back
      @(negedge clk);
      rst0 = 1'b1;
      en0  = 1'b0;
      @(posedge clk); #5;
      check("R6", "reset before lap", 32'(q0), 32'h8);
      @(negedge clk);
      rst0 = 1'b0;
      en0  = 1'b1;
      laps = 0;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk); #5;
         laps++;
         check("R1", "lap state one-hot", 32'($countones(q0)), 32'd1);
         if (q0 == 4'b1000) break;
      end
      check("R1", "modulus", 32'(laps), 32'd4);

      @(negedge clk);
      en0 = 1'b0;
      repeat (2) @(posedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule